// File: doc/BRIEF.md
# Inertial Threshold Interrupt Generator

This block watches a stream of three-axis acceleration samples, given in milli-g as signed values, and decides for every sample which axes have moved past a programmable magnitude window. Each axis yields two events: one for a reading above the positive threshold and one for a reading below the negative threshold. The threshold register counts steps whose size in milli-g follows the selected full-scale range. Six enables choose which of these events take part. A two-bit mode combines them as an OR, as an AND, or as one of two orientation detectors.

A combined condition passes only after it has held for a programmed number of consecutive samples. The result goes into a seven-bit source register and drives an interrupt pin with selectable polarity. When latching is enabled, an interrupt freezes the source register and the pin until a read strobe clears them. Host logic pulses `smp_stb` once per new sample and pulses `src_rd` when it consumes the source register.

Top module: `inertial_irq_gen`

## Requirements
- R1: For each axis the high event is set when the sample is strictly greater than L, and the low event when it is strictly less than -L. L = thr_cfg × step, with step = 16, 32, 62 or 186 mg for fs_sel = 0, 1, 2 or 3. A sample equal to ±L raises no event.
- R2: On every `smp_stb` the source register loads the masked events, with bit 0 X low, bit 1 X high, bit 2 Y low, bit 3 Y high, bit 4 Z low and bit 5 Z high (each ANDed with the same bit of evt_en). Bit 6 carries the interrupt-active flag. Between strobes and reads the register does not change.
- R3: In mode 0 (OR) the condition is true when any enabled event is set.
- R4: In mode 2 (AND) the condition is true when every enabled event is set and at least one enable is set.
- R5: A condition is recognised on the sample where it has already held for dur_cfg consecutive earlier samples. A sample without the condition restarts the count, and dur_cfg = 0 recognises the first qualifying sample.
- R6: In mode 1 (movement) the orientation is known when exactly one enabled event is set. The active flag is set only on the recognised sample that follows a sample not recognised as known, so it lasts one sample period.
- R7: In mode 3 (position) the active flag is set on every sample whose known orientation (defined as in R6) is recognised.
- R8: With evt_en = 0 the active flag never rises, in any mode.
- R9: With latch_en = 1, a set active flag freezes the source register against further samples until `src_rd` clears the register to zero. A read in the same cycle as a sample loads that sample. With latch_en = 0, `src_rd` has no effect.
- R10: irq_o equals the active flag when act_low = 0 and its inverse when act_low = 1.
- R11: After reset the source register is 0 and irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | One-cycle pulse marking a new sample |
| ax_x | input | AXIS_W | X-axis sample, signed, mg |
| ax_y | input | AXIS_W | Y-axis sample, signed, mg |
| ax_z | input | AXIS_W | Z-axis sample, signed, mg |
| fs_sel | input | 2 | Full-scale range select (threshold step) |
| thr_cfg | input | THR_W | Threshold in steps |
| dur_cfg | input | DUR_W | Required consecutive samples |
| evt_en | input | 6 | Per-event enables |
| comb_mode | input | 2 | 0 OR, 1 movement, 2 AND, 3 position |
| latch_en | input | 1 | Hold source until read |
| act_low | input | 1 | Pin polarity: 1 makes the pin active low |
| src_rd | input | 1 | Source register read strobe |
| irq_o | output | 1 | Interrupt pin |
| src_o | output | 7 | Source register: active flag and event bits |

## Verification
The checker watches every cycle for the following: the source register holding between strobes, the pin tracking the active flag under the chosen polarity, a latched register staying frozen until read, a read clearing it, and the active flag never rising without enables. It also checks that an AND interrupt always reports exactly the enabled set and that an OR interrupt reports at least one event. Other behaviour depends on sample history and appears only in the bench's scenarios. This covers threshold edges at each full-scale step, the duration count and its restart, the one-sample movement pulse against the persistent position flag, and the full sweep of enables against axis patterns in every mode.

// File: rtl/inertial_irq_pkg.sv
package inertial_irq_pkg;
  localparam int AXES = 3;
  localparam int EV_W = 2 * AXES;
  localparam int SRC_W = EV_W + 1;

  typedef enum logic [1:0] {
    MODE_OR   = 2'd0,
    MODE_MOVE = 2'd1,
    MODE_AND  = 2'd2,
    MODE_POS  = 2'd3
  } combine_mode_e;

  // milli-g per threshold step for each full-scale setting
  function automatic logic [7:0] step_mg(input logic [1:0] fs);
    case (fs)
      2'd0:    step_mg = 8'd16;
      2'd1:    step_mg = 8'd32;
      2'd2:    step_mg = 8'd62;
      default: step_mg = 8'd186;
    endcase
  endfunction
endpackage

// File: rtl/inertial_axis_window.sv
module inertial_axis_window #(
  parameter int AXIS_W = 16,
  parameter int LIM_W  = 15
) (
  input  logic signed [AXIS_W-1:0] sample_i,
  input  logic        [LIM_W-1:0]  limit_i,
  output logic                     below_o,
  output logic                     above_o
);
  localparam int CW = ((AXIS_W > LIM_W) ? AXIS_W : LIM_W) + 2;

  logic signed [CW-1:0] s_ext;
  logic signed [CW-1:0] lim_pos;
  logic signed [CW-1:0] lim_neg;

  assign s_ext   = CW'(sample_i);
  assign lim_pos = $signed({{(CW-LIM_W){1'b0}}, limit_i});
  assign lim_neg = -lim_pos;
  assign above_o = (s_ext > lim_pos);
  assign below_o = (s_ext < lim_neg);
endmodule

// File: rtl/inertial_event_qualifier.sv
module inertial_event_qualifier
  import inertial_irq_pkg::*;
#(
  parameter int DUR_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe_i,
  input  logic [EV_W-1:0]  evm_i,
  input  logic [EV_W-1:0]  en_i,
  input  logic [1:0]       mode_i,
  input  logic [DUR_W-1:0] dur_i,
  output logic             fire_o
);
  localparam logic [DUR_W-1:0] CNT_MAX = {DUR_W{1'b1}};

  logic [DUR_W-1:0] cnt_q;
  logic             prev_q;
  logic             cond;
  logic             known;
  logic             qual;
  combine_mode_e    mode;

  assign mode  = combine_mode_e'(mode_i);
  assign known = ($countones(evm_i) == 1);

  always_comb begin
    case (mode)
      MODE_OR:  cond = |evm_i;
      MODE_AND: cond = (|en_i) && (evm_i == en_i);
      default:  cond = known;
    endcase
  end

  assign qual   = cond && (cnt_q >= dur_i);
  assign fire_o = (mode == MODE_MOVE) ? (qual && !prev_q) : qual;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      prev_q <= 1'b0;
    end else if (strobe_i) begin
      prev_q <= qual;
      if (!cond)
        cnt_q <= '0;
      else if (cnt_q != CNT_MAX)
        cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/inertial_src_holder.sv
module inertial_src_holder
  import inertial_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe_i,
  input  logic             fire_i,
  input  logic [EV_W-1:0]  evm_i,
  input  logic             latch_i,
  input  logic             rd_i,
  input  logic             act_low_i,
  output logic [SRC_W-1:0] src_o,
  output logic             irq_o
);
  logic [SRC_W-1:0] src_q;
  logic [SRC_W-1:0] src_d;
  logic             irq_q;
  logic             held;

  assign held = latch_i && src_q[SRC_W-1];

  always_comb begin
    src_d = src_q;
    if (strobe_i && (!held || rd_i))
      src_d = {fire_i, evm_i};
    else if (rd_i && latch_i)
      src_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= '0;
      irq_q <= 1'b0;
    end else begin
      src_q <= src_d;
      irq_q <= src_d[SRC_W-1] ^ act_low_i;
    end
  end

  assign src_o = src_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/inertial_irq_gen.sv
module inertial_irq_gen
  import inertial_irq_pkg::*;
#(
  parameter int AXIS_W = 16,
  parameter int THR_W  = 7,
  parameter int DUR_W  = 7
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     smp_stb,
  input  logic signed [AXIS_W-1:0] ax_x,
  input  logic signed [AXIS_W-1:0] ax_y,
  input  logic signed [AXIS_W-1:0] ax_z,
  input  logic [1:0]               fs_sel,
  input  logic [THR_W-1:0]         thr_cfg,
  input  logic [DUR_W-1:0]         dur_cfg,
  input  logic [5:0]               evt_en,
  input  logic [1:0]               comb_mode,
  input  logic                     latch_en,
  input  logic                     act_low,
  input  logic                     src_rd,
  output logic                     irq_o,
  output logic [6:0]               src_o
);
  localparam int LIM_W = THR_W + 8;

  logic signed [AXIS_W-1:0] axv [AXES];
  logic [LIM_W-1:0]         limit;
  logic [EV_W-1:0]          ev_raw;
  logic [EV_W-1:0]          ev_masked;
  logic                     fire;

  assign axv[0] = ax_x;
  assign axv[1] = ax_y;
  assign axv[2] = ax_z;

  assign limit = LIM_W'(thr_cfg) * LIM_W'(step_mg(fs_sel));

  for (genvar a = 0; a < AXES; a++) begin : g_axis
    inertial_axis_window #(
      .AXIS_W (AXIS_W),
      .LIM_W  (LIM_W)
    ) win_i (
      .sample_i (axv[a]),
      .limit_i  (limit),
      .below_o  (ev_raw[2*a]),
      .above_o  (ev_raw[2*a+1])
    );
  end

  assign ev_masked = ev_raw & evt_en;

  inertial_event_qualifier #(
    .DUR_W (DUR_W)
  ) qual_i (
    .clk      (clk),
    .rst      (rst),
    .strobe_i (smp_stb),
    .evm_i    (ev_masked),
    .en_i     (evt_en),
    .mode_i   (comb_mode),
    .dur_i    (dur_cfg),
    .fire_o   (fire)
  );

  inertial_src_holder hold_i (
    .clk       (clk),
    .rst       (rst),
    .strobe_i  (smp_stb),
    .fire_i    (fire),
    .evm_i     (ev_masked),
    .latch_i   (latch_en),
    .rd_i      (src_rd),
    .act_low_i (act_low),
    .src_o     (src_o),
    .irq_o     (irq_o)
  );
endmodule

// File: rtl/inertial_irq_chk.sv
module inertial_irq_chk (
  input logic       clk,
  input logic       rst,
  input logic       smp_stb,
  input logic [5:0] evt_en,
  input logic [1:0] comb_mode,
  input logic       latch_en,
  input logic       act_low,
  input logic       src_rd,
  input logic       irq_o,
  input logic [6:0] src_o
);
  // R2
  src_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(smp_stb) && !$past(src_rd)) |-> $stable(src_o));

  // R10
  pin_pol_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_o == (src_o[6] ^ $past(act_low))));

  // R9
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(latch_en) && $past(src_o[6]) && !$past(src_rd)) |-> $stable(src_o));

  // R9
  rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(latch_en) && $past(src_rd) && !$past(smp_stb)) |-> (src_o == 7'd0));

  // R8
  no_en_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(src_o[6]) |-> ($past(evt_en) != 6'd0));

  // R4
  and_all_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(src_o[6]) && ($past(comb_mode) == 2'd2)) |-> (src_o[5:0] == $past(evt_en)));

  // R3
  or_any_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(src_o[6]) && ($past(comb_mode) == 2'd0)) |-> (src_o[5:0] != 6'd0));
endmodule

bind inertial_irq_gen inertial_irq_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .smp_stb   (smp_stb),
  .evt_en    (evt_en),
  .comb_mode (comb_mode),
  .latch_en  (latch_en),
  .act_low   (act_low),
  .src_rd    (src_rd),
  .irq_o     (irq_o),
  .src_o     (src_o)
);

// File: tb/inertial_irq_gen_tb.sv
module inertial_irq_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               smp_stb = 1'b0;
  logic signed [15:0] ax_x = '0;
  logic signed [15:0] ax_y = '0;
  logic signed [15:0] ax_z = '0;
  logic [1:0]         fs_sel = '0;
  logic [6:0]         thr_cfg = '0;
  logic [6:0]         dur_cfg = '0;
  logic [5:0]         evt_en = '0;
  logic [1:0]         comb_mode = '0;
  logic               latch_en = 1'b0;
  logic               act_low = 1'b0;
  logic               src_rd = 1'b0;
  logic               irq_o;
  logic [6:0]         src_o;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;

  int         cnt_m = 0;
  bit         pq_m  = 1'b0;
  logic [6:0] src_m = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  inertial_irq_gen dut_i (
    .clk(clk), .rst(rst), .smp_stb(smp_stb),
    .ax_x(ax_x), .ax_y(ax_y), .ax_z(ax_z),
    .fs_sel(fs_sel), .thr_cfg(thr_cfg), .dur_cfg(dur_cfg),
    .evt_en(evt_en), .comb_mode(comb_mode), .latch_en(latch_en),
    .act_low(act_low), .src_rd(src_rd), .irq_o(irq_o), .src_o(src_o)
  );

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired: got cycle %0d expected below %0d", cyc, WATCHDOG);
      summary();
      $finish;
    end
  end

  function automatic int step_of(int fs);
    case (fs)
      0: return 16;
      1: return 32;
      2: return 62;
      default: return 186;
    endcase
  endfunction

  function automatic logic [5:0] ev_of(int x, int y, int z);
    int lim = int'(thr_cfg) * step_of(int'(fs_sel));
    logic [5:0] e;
    e[0] = (x < -lim); e[1] = (x > lim);
    e[2] = (y < -lim); e[3] = (y > lim);
    e[4] = (z < -lim); e[5] = (z > lim);
    return e;
  endfunction

  task automatic chk(string tag, logic [6:0] got, logic [6:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic check_outs(string tag);
    chk({tag, " src"}, src_o, src_m);
    chk({tag, " pin(R10)"}, {6'd0, irq_o}, {6'd0, src_m[6] ^ act_low});
  endtask

  task automatic sample(int x, int y, int z, bit rd, string tag);
    logic [5:0] evm;
    bit cond, qual, fire;
    @(negedge clk);
    ax_x = 16'(x); ax_y = 16'(y); ax_z = 16'(z);
    smp_stb = 1'b1;
    src_rd = rd;
    evm = ev_of(x, y, z) & evt_en;
    case (comb_mode)
      2'd0: cond = (evm != 0);
      2'd2: cond = (evt_en != 0) && (evm == evt_en);
      default: cond = ($countones(evm) == 1);
    endcase
    qual = cond && (cnt_m >= int'(dur_cfg));
    fire = (comb_mode == 2'd1) ? (qual && !pq_m) : qual;
    pq_m = qual;
    cnt_m = cond ? ((cnt_m < 127) ? cnt_m + 1 : 127) : 0;
    if (!latch_en || !src_m[6] || rd) src_m = {fire, evm};
    @(posedge clk); #1;
    smp_stb = 1'b0;
    src_rd = 1'b0;
    check_outs(tag);
  endtask

  task automatic read_src(string tag);
    @(negedge clk);
    src_rd = 1'b1;
    if (latch_en) src_m = '0;
    @(posedge clk); #1;
    src_rd = 1'b0;
    check_outs(tag);
  endtask

  task automatic idle(string tag);
    @(posedge clk); #1;
    check_outs(tag);
  endtask

  task automatic cfg(int mode, int en, int n, bit lat);
    @(negedge clk);
    comb_mode = 2'(mode);
    evt_en = 6'(en);
    dur_cfg = 7'(n);
    latch_en = lat;
  endtask

  initial begin
    int vals[3] = '{-200, 0, 200};
    int thrs[4] = '{0, 1, 5, 127};
    int durs[4] = '{0, 1, 2, 5};

    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    // R11 reset state
    chk("R11 src after reset", src_o, 7'd0);
    chk("R11 pin after reset", {6'd0, irq_o}, 7'd0);

    // R1: threshold boundaries for every full-scale and axis
    cfg(0, 63, 0, 1'b0);
    for (int fs = 0; fs < 4; fs++) begin
      for (int t = 0; t < 4; t++) begin
        @(negedge clk);
        fs_sel = 2'(fs);
        thr_cfg = 7'(thrs[t]);
        for (int ax = 0; ax < 3; ax++) begin
          for (int d = -1; d <= 1; d++) begin
            for (int sg = 0; sg < 2; sg++) begin
              int lim = thrs[t] * step_of(fs);
              int v = (sg == 0) ? (lim + d) : -(lim + d);
              sample((ax == 0) ? v : 0, (ax == 1) ? v : 0, (ax == 2) ? v : 0, 1'b0, "R1 threshold");
            end
          end
        end
      end
    end

    // R2 R3 R4 R6 R7 R8: enables against axis patterns in every mode
    @(negedge clk);
    fs_sel = 2'd0;
    thr_cfg = 7'd10;
    for (int m = 0; m < 4; m++) begin
      for (int en = 0; en < 64; en++) begin
        cfg(m, en, 0, 1'b0);
        for (int p = 0; p < 27; p++) begin
          sample(vals[p % 3], vals[(p / 3) % 3], vals[p / 9],
                 1'b0, (m == 0) ? "R3 OR" : (m == 1) ? "R6 move" :
                       (m == 2) ? "R4 AND" : (en == 0) ? "R8 none" : "R7 pos");
        end
      end
    end

    // R2: no change without strobe or read
    idle("R2 hold");

    // R5: duration count and restart
    for (int k = 0; k < 4; k++) begin
      cfg(0, 2, durs[k], 1'b0);
      sample(0, 0, 0, 1'b0, "R5 clear");
      for (int i = 0; i < durs[k] + 2; i++) sample(300, 0, 0, 1'b0, "R5 run");
      sample(0, 0, 0, 1'b0, "R5 drop");
      for (int i = 0; i < durs[k] + 1; i++) sample(300, 0, 0, 1'b0, "R5 rerun");
    end

    // R6 movement pulse and R7 position persistence, explicit sequences
    cfg(1, 63, 0, 1'b0);
    sample(0, 0, 0, 1'b0, "R6 unknown");
    sample(300, 0, 0, 1'b0, "R6 enter");
    sample(300, 0, 0, 1'b0, "R6 stay");
    sample(300, 300, 0, 1'b0, "R6 two axes");
    sample(300, 0, 0, 1'b0, "R6 reenter");
    cfg(3, 63, 1, 1'b0);
    sample(0, 0, 0, 1'b0, "R7 unknown");
    sample(0, -300, 0, 1'b0, "R7 first");
    sample(0, -300, 0, 1'b0, "R7 held");
    sample(0, -300, 0, 1'b0, "R7 held2");
    sample(0, 0, 0, 1'b0, "R7 leave");

    // R9: latching and clear on read
    cfg(0, 63, 0, 1'b1);
    sample(0, 0, 300, 1'b0, "R9 latch set");
    sample(0, 0, 0, 1'b0, "R9 held quiet");
    sample(-300, 0, 0, 1'b0, "R9 held other");
    read_src("R9 read clears");
    sample(0, 0, 0, 1'b0, "R9 after read");
    sample(0, 300, 0, 1'b0, "R9 set again");
    sample(300, 0, 0, 1'b1, "R9 read with sample");
    cfg(0, 63, 0, 1'b0);
    sample(0, 300, 0, 1'b0, "R9 unlatched set");
    read_src("R9 read ignored");

    // R10: active-low pin
    @(negedge clk);
    act_low = 1'b1;
    idle("R10 polarity flip");
    sample(0, 0, 0, 1'b0, "R10 low idle");
    sample(0, 0, 300, 1'b0, "R10 low active");
    @(negedge clk);
    act_low = 1'b0;
    idle("R10 back high");

    summary();
    $finish;
  end
endmodule